// File: doc/BRIEF.md
# Fault and Auto-Restart Sequencer

This block is the supervisory state machine of an off-line switching controller. It decides when the high-voltage start-up current source charges the supply capacitor, and when the power switch may run. It handles the start-up window with its soft-start ramp of the peak-current limit and its clamp on the feedback signal. It reacts to every shutdown condition: a double second-level overcurrent trip, feedback overload, output overvoltage, supply undervoltage, brown-out and over-temperature. After a latched fault it runs an auto-restart through supply hysteresis.

All inputs are single-bit flags from analog comparators, already synchronous to `clk`. Each hysteretic comparator supplies one flag for entering its condition and one for leaving it. `cycle_strobe` pulses once per switching cycle and qualifies `ocp2_trip`. The state is a one-hot enumeration of seven states: off, charging, start-up, running, burst pause, overcurrent warning and fault wait. The start-up window and the soft-start duration are parameters counted in clock cycles.

Top module: `fault_restart_seq`

## Requirements
- R1: While `rst_n` is low, at the first clock edge every output is cleared: no switching, no charging, `ss_limit` = 0 and `fault_status` = 0.
- R2: The charge source (`chg_en`) turns on only while `drain_above_start` is high and no brown-out or thermal inhibit is active. When `vdd_above_on` is seen during charging, `chg_en` drops and `sw_en` rises on the same edge. `sw_en` and `chg_en` are never high together.
- R3: Let k be the number of clocks since switching began. `ss_limit` takes the value min(LIM_MAX, floor(k*LIM_MAX/SS_CYCLES)) only at `cycle_strobe` edges. It holds between strobes, never decreases while the block is active, and is 0 while the block is inactive.
- R4: For the first SU_CYCLES clocks after switching begins, `fb_clamp` is high and `fb_overload` causes no shutdown.
- R5: After the start-up window, `fb_overload` stops switching and enters the fault wait.
- R6: A first `ocp2_trip` at a strobe enters the warning state while switching continues. A strobe without a trip returns the block to normal operation. A trip at two consecutive strobes stops switching and enters the fault wait.
- R7: `ovp_fault` during switching stops switching and enters the fault wait.
- R8: In the fault wait both `chg_en` and `sw_en` stay low until `vdd_below_restart`. Charging then resumes with `chg_reduced` high. `chg_reduced` is only ever high together with `chg_en`, and it clears once a restart succeeds.
- R9: `vdd_below_off` stops switching. If `drain_above_start` is high at that time, the block enters the fault wait. If it is low, the block goes to off and stays idle until `drain_above_start` rises again. It then charges at normal current.
- R10: In running state, `fb_burst_low` pauses switching (`burst_pause` high). The pause holds until `fb_burst_high`, even after `fb_burst_low` has cleared.
- R11: `brownout_low` or `thermal_hot` stops switching at once and goes to off without reduced current. The inhibit holds until `brownout_ok` (or `thermal_cool`) is seen. Charging then resumes at normal current.
- R12: `fault_status` is sticky. Bit 0 is a double overcurrent trip, bit 1 is overload, bit 2 is overvoltage, bit 3 is undervoltage, bit 4 is brown-out and bit 5 is thermal. Each bit is set when its condition is seen while the block is active. All bits clear when charging hands over to switching.
- R13: When conditions coincide, brown-out or thermal takes precedence over undervoltage, and undervoltage takes precedence over the other faults. An inhibit plus overvoltage in the same cycle therefore leads to off, not to a reduced-current restart. Both status bits are still recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vdd_above_on | input | 1 | Supply above turn-on threshold |
| vdd_below_off | input | 1 | Supply below undervoltage threshold |
| vdd_below_restart | input | 1 | Supply below restart threshold |
| drain_above_start | input | 1 | Drain voltage above start level |
| cycle_strobe | input | 1 | One pulse per switching cycle |
| ocp2_trip | input | 1 | Second-level overcurrent comparator, valid with strobe |
| fb_overload | input | 1 | Feedback at overload threshold |
| fb_burst_low | input | 1 | Feedback below burst threshold |
| fb_burst_high | input | 1 | Feedback above burst threshold plus hysteresis |
| brownout_low | input | 1 | Line sense below brown-out threshold |
| brownout_ok | input | 1 | Line sense above threshold plus hysteresis |
| thermal_hot | input | 1 | Junction above shutdown temperature |
| thermal_cool | input | 1 | Junction cooled by the hysteresis |
| ovp_fault | input | 1 | Filtered output overvoltage fault |
| sw_en | output | 1 | Switching enable |
| chg_en | output | 1 | Start-up charge source enable |
| chg_reduced | output | 1 | Charge source at reduced current |
| ss_limit | output | LIM_W | Soft-start peak-current limit code |
| fb_clamp | output | 1 | Clamp feedback at linear limit |
| burst_pause | output | 1 | Switching paused by burst control |
| fault_status | output | 6 | Sticky fault causes |

## Verification
A behavioural reference model runs beside the design and is compared on every clock through a scripted power-up. The run includes overload held high inside the start-up window, which separates the masked window from the armed state that follows. Overcurrent trips are applied both as a single-strobe window and as a two-strobe window, which separates the warning state from the shutdown. The block then goes through an overvoltage fault, an overload fault, undervoltage with the drain high and with the drain low, a brown-out, a thermal event, and an inhibit that coincides with overvoltage. Between them these tell apart the reduced-current fault path, the non-latching path at normal current and the priority order. Burst entry followed by a clearing of the low flag alone shows that the exit depends on the hysteresis flag.

// File: rtl/frs_pkg.sv
// Package: shared state encoding and fault-cause bit positions for the
// fault and auto-restart sequencer.
package frs_pkg;

    // One-hot sequencer states.
    typedef enum logic [6:0] {
        ST_OFF    = 7'b000_0001,
        ST_CHARGE = 7'b000_0010,
        ST_SOFT   = 7'b000_0100,
        ST_RUN    = 7'b000_1000,
        ST_BURST  = 7'b001_0000,
        ST_WARN   = 7'b010_0000,
        ST_WAIT   = 7'b100_0000
    } seq_state_e;

    localparam int CAUSE_W     = 6;
    localparam int CAUSE_OCP2  = 0;
    localparam int CAUSE_OVL   = 1;
    localparam int CAUSE_OVP   = 2;
    localparam int CAUSE_UVLO  = 3;
    localparam int CAUSE_BROWN = 4;
    localparam int CAUSE_THERM = 5;

endpackage

// File: rtl/frs_startup_timer.sv
// Module: start-up window counter and soft-start ramp.
// Counts clocks while the sequencer is active (saturating at SU_CYCLES),
// builds the ramp floor(k*LIM_MAX/SS_CYCLES) by error accumulation and
// latches it into ss_limit on each cycle strobe.
// Assumes LIM_MAX <= SS_CYCLES <= SU_CYCLES and LIM_MAX < 2**LIM_W.
module frs_startup_timer #(
    parameter int SU_CYCLES = 64,
    parameter int SS_CYCLES = 40,
    parameter int LIM_W     = 6,
    parameter int LIM_MAX   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             cycle_strobe,
    output logic             su_last,
    output logic             su_done,
    output logic [LIM_W-1:0] ss_limit
);

    localparam int CNT_W = $clog2(SU_CYCLES + 1);
    localparam int ACC_W = $clog2(SS_CYCLES + LIM_MAX + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_sum;
    logic [LIM_W-1:0] level_q;
    logic             level_full;

    assign su_done    = (cnt_q == CNT_W'(SU_CYCLES));
    assign su_last    = (cnt_q == CNT_W'(SU_CYCLES - 1));
    assign level_full = (level_q == LIM_W'(LIM_MAX));
    assign acc_sum    = acc_q + ACC_W'(LIM_MAX);

    // Start-up window counter, cleared whenever the sequencer is inactive.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            cnt_q <= '0;
        end else if (!su_done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Ramp generator: one error-accumulation step per clock until full.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            acc_q   <= '0;
            level_q <= '0;
        end else if (!level_full) begin
            if (acc_sum >= ACC_W'(SS_CYCLES)) begin
                acc_q   <= acc_sum - ACC_W'(SS_CYCLES);
                level_q <= level_q + 1'b1;
            end else begin
                acc_q   <= acc_sum;
            end
        end
    end

    // Applied limit: takes the ramp value only at switching-cycle boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            ss_limit <= '0;
        end else if (cycle_strobe) begin
            ss_limit <= level_q;
        end
    end

endmodule

// File: rtl/frs_guard.sv
// Module: hysteretic brown-out / thermal inhibit and sticky fault causes.
// Each inhibit is set by its entry flag and cleared by its exit flag; the
// entry flag also acts in the same cycle. Causes are captured only while the
// sequencer is active and are cleared by a successful restart.
module frs_guard #(
    parameter int CAUSE_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               brownout_low,
    input  logic               brownout_ok,
    input  logic               thermal_hot,
    input  logic               thermal_cool,
    input  logic               active,
    input  logic [CAUSE_W-1:0] cause_set,
    input  logic               restart_ok,
    output logic               inhibit,
    output logic [CAUSE_W-1:0] fault_status
);

    logic bo_q;
    logic th_q;

    assign inhibit = brownout_low | thermal_hot | bo_q | th_q;

    // Hysteretic hold flags for brown-out and over-temperature.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bo_q <= 1'b0;
            th_q <= 1'b0;
        end else begin
            if (brownout_low)     bo_q <= 1'b1;
            else if (brownout_ok) bo_q <= 1'b0;
            if (thermal_hot)       th_q <= 1'b1;
            else if (thermal_cool) th_q <= 1'b0;
        end
    end

    // Sticky cause register.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_ok) begin
            fault_status <= '0;
        end else if (active) begin
            fault_status <= fault_status | cause_set;
        end
    end

endmodule

// File: rtl/fault_restart_seq.sv
// Module: supervisory sequencer of the controller (top).
// Runs power-up from the start-up charge source, the start-up window with
// soft-start and feedback clamp, burst pause, the two-strike second-level
// overcurrent shutdown and all other shutdowns, and auto-restart through the
// supply restart level at reduced charge current.
// Assumes all inputs are synchronous comparator flags.
module fault_restart_seq
    import frs_pkg::*;
#(
    parameter int SU_CYCLES = 64,
    parameter int SS_CYCLES = 40,
    parameter int LIM_W     = 6,
    parameter int LIM_MAX   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vdd_above_on,
    input  logic               vdd_below_off,
    input  logic               vdd_below_restart,
    input  logic               drain_above_start,
    input  logic               cycle_strobe,
    input  logic               ocp2_trip,
    input  logic               fb_overload,
    input  logic               fb_burst_low,
    input  logic               fb_burst_high,
    input  logic               brownout_low,
    input  logic               brownout_ok,
    input  logic               thermal_hot,
    input  logic               thermal_cool,
    input  logic               ovp_fault,
    output logic               sw_en,
    output logic               chg_en,
    output logic               chg_reduced,
    output logic [LIM_W-1:0]   ss_limit,
    output logic               fb_clamp,
    output logic               burst_pause,
    output logic [CAUSE_W-1:0] fault_status
);

    seq_state_e         state_q;
    seq_state_e         state_nx;
    logic               active;
    logic               su_last;
    logic               su_done;
    logic               inhibit;
    logic               restart_ok;
    logic               reduced_q;
    logic               ocp_hit;
    logic [CAUSE_W-1:0] cause_set;

    assign active  = (state_q == ST_SOFT) || (state_q == ST_RUN) ||
                     (state_q == ST_BURST) || (state_q == ST_WARN);
    assign ocp_hit = cycle_strobe && ocp2_trip;

    frs_startup_timer #(
        .SU_CYCLES (SU_CYCLES),
        .SS_CYCLES (SS_CYCLES),
        .LIM_W     (LIM_W),
        .LIM_MAX   (LIM_MAX)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .active       (active),
        .cycle_strobe (cycle_strobe),
        .su_last      (su_last),
        .su_done      (su_done),
        .ss_limit     (ss_limit)
    );

    // Cause vector presented to the sticky register.
    always_comb begin : cause_map
        cause_set              = '0;
        cause_set[CAUSE_OCP2]  = (state_q == ST_WARN) && ocp_hit;
        cause_set[CAUSE_OVL]   = fb_overload && su_done;
        cause_set[CAUSE_OVP]   = ovp_fault;
        cause_set[CAUSE_UVLO]  = vdd_below_off;
        cause_set[CAUSE_BROWN] = brownout_low;
        cause_set[CAUSE_THERM] = thermal_hot;
    end

    frs_guard #(
        .CAUSE_W (CAUSE_W)
    ) u_guard (
        .clk          (clk),
        .rst_n        (rst_n),
        .brownout_low (brownout_low),
        .brownout_ok  (brownout_ok),
        .thermal_hot  (thermal_hot),
        .thermal_cool (thermal_cool),
        .active       (active),
        .cause_set    (cause_set),
        .restart_ok   (restart_ok),
        .inhibit      (inhibit),
        .fault_status (fault_status)
    );

    // Next-state selection with shutdown priority: inhibit, UVLO, faults.
    always_comb begin : next_state
        state_nx = state_q;
        case (state_q)
            ST_OFF: begin
                if (!inhibit && drain_above_start) state_nx = ST_CHARGE;
            end
            ST_CHARGE: begin
                if (inhibit || !drain_above_start) state_nx = ST_OFF;
                else if (vdd_above_on)             state_nx = ST_SOFT;
            end
            ST_WAIT: begin
                if (vdd_below_restart) state_nx = ST_CHARGE;
            end
            default: begin
                if (inhibit) begin
                    state_nx = ST_OFF;
                end else if (vdd_below_off) begin
                    state_nx = drain_above_start ? ST_WAIT : ST_OFF;
                end else if (ovp_fault || (fb_overload && su_done)) begin
                    state_nx = ST_WAIT;
                end else begin
                    case (state_q)
                        ST_SOFT: begin
                            if (ocp_hit)                  state_nx = ST_WARN;
                            else if (su_last || su_done)  state_nx = ST_RUN;
                        end
                        ST_RUN: begin
                            if (ocp_hit)           state_nx = ST_WARN;
                            else if (fb_burst_low) state_nx = ST_BURST;
                        end
                        ST_WARN: begin
                            if (ocp_hit)           state_nx = ST_WAIT;
                            else if (cycle_strobe) state_nx = su_done ? ST_RUN : ST_SOFT;
                        end
                        ST_BURST: begin
                            if (fb_burst_high) state_nx = ST_RUN;
                        end
                        default: state_nx = state_q;
                    endcase
                end
            end
        endcase
    end

    assign restart_ok = (state_q == ST_CHARGE) && (state_nx == ST_SOFT);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_nx;
    end

    // Reduced-charge memory: armed by any fault wait, cleared by a restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_ok) begin
            reduced_q <= 1'b0;
        end else if ((state_nx == ST_WAIT) && (state_q != ST_WAIT)) begin
            reduced_q <= 1'b1;
        end
    end

    assign sw_en       = (state_q == ST_SOFT) || (state_q == ST_RUN) || (state_q == ST_WARN);
    assign chg_en      = (state_q == ST_CHARGE);
    assign chg_reduced = (state_q == ST_CHARGE) && reduced_q;
    assign fb_clamp    = (state_q == ST_SOFT) || ((state_q == ST_WARN) && !su_done);
    assign burst_pause = (state_q == ST_BURST);

endmodule

// File: rtl/frs_checker.sv
// Module: property checker for the sequencer, bound into the top module.
// Observes ports and the state, inhibit and cause signals between sub-blocks.
module frs_checker
    import frs_pkg::*;
#(
    parameter int LIM_W   = 6,
    parameter int LIM_MAX = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [6:0]         state_bits,
    input logic               inhibit,
    input logic               sw_en,
    input logic               chg_en,
    input logic               chg_reduced,
    input logic               burst_pause,
    input logic               fb_clamp,
    input logic [LIM_W-1:0]   ss_limit,
    input logic               vdd_above_on,
    input logic               vdd_below_off,
    input logic               vdd_below_restart,
    input logic               cycle_strobe,
    input logic               ocp2_trip,
    input logic               fb_overload,
    input logic               ovp_fault,
    input logic [CAUSE_W-1:0] fault_status
);

    logic act_now;
    assign act_now = sw_en || burst_pause;

    p_state_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_bits) == 1);

    p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_en && chg_en));

    p_start_on_supply_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(chg_en) && sw_en) |-> $past(vdd_above_on));

    p_ss_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ss_limit <= LIM_W'(LIM_MAX));

    p_ss_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(act_now) && act_now) |-> (ss_limit >= $past(ss_limit)));

    p_ss_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(act_now) && act_now && !$past(cycle_strobe)) |-> $stable(ss_limit));

    p_clamp_masks_ovl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_clamp && fb_overload && !ovp_fault && !vdd_below_off && !inhibit &&
         !(cycle_strobe && ocp2_trip)) |=> sw_en);

    p_double_trip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_bits == ST_WARN) && cycle_strobe && ocp2_trip) |=> !sw_en);

    p_reduced_in_charge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        chg_reduced |-> chg_en);

    p_wait_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_bits == ST_WAIT) && !vdd_below_restart) |=> (!chg_en && !sw_en));

    p_burst_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        burst_pause |-> !sw_en);

    p_inhibit_stops_r11: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |=> !sw_en);

    p_status_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(chg_en) |-> ((fault_status & $past(fault_status)) == $past(fault_status)));

endmodule

bind fault_restart_seq frs_checker #(
    .LIM_W   (LIM_W),
    .LIM_MAX (LIM_MAX)
) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .state_bits        (state_q),
    .inhibit           (inhibit),
    .sw_en             (sw_en),
    .chg_en            (chg_en),
    .chg_reduced       (chg_reduced),
    .burst_pause       (burst_pause),
    .fb_clamp          (fb_clamp),
    .ss_limit          (ss_limit),
    .vdd_above_on      (vdd_above_on),
    .vdd_below_off     (vdd_below_off),
    .vdd_below_restart (vdd_below_restart),
    .cycle_strobe      (cycle_strobe),
    .ocp2_trip         (ocp2_trip),
    .fb_overload       (fb_overload),
    .ovp_fault         (ovp_fault),
    .fault_status      (fault_status)
);

// File: tb/fault_restart_seq_tb.sv
// Bench: scripted stimulus, behavioural reference model compared every clock,
// plus targeted checks per requirement.
module fault_restart_seq_tb;

    localparam int SU   = 64;
    localparam int SS   = 40;
    localparam int LW   = 6;
    localparam int LMAX = 32;

    localparam int S_OFF = 0, S_CHG = 1, S_SS = 2, S_RUN = 3, S_BURST = 4, S_WARN = 5, S_WAIT = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vdd_above_on = 0, vdd_below_off = 0, vdd_below_restart = 0, drain_above_start = 0;
    logic cycle_strobe = 0, ocp2_trip = 0, fb_overload = 0, fb_burst_low = 0, fb_burst_high = 1;
    logic brownout_low = 0, brownout_ok = 1, thermal_hot = 0, thermal_cool = 1, ovp_fault = 0;
    logic          sw_en, chg_en, chg_reduced, fb_clamp, burst_pause;
    logic [LW-1:0] ss_limit;
    logic [5:0]    fault_status;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 0;
    bit done = 0;
    bit strobe_on = 0;
    int cyc = 0;

    // Reference model state.
    int m_st = S_OFF, m_k = 0, m_sslim = 0, m_stat = 0;
    bit m_red = 0, m_bo = 0, m_th = 0;

    always #2 clk = ~clk;

    fault_restart_seq #(
        .SU_CYCLES (SU), .SS_CYCLES (SS), .LIM_W (LW), .LIM_MAX (LMAX)
    ) u_dut (
        .clk (clk), .rst_n (rst_n),
        .vdd_above_on (vdd_above_on), .vdd_below_off (vdd_below_off),
        .vdd_below_restart (vdd_below_restart), .drain_above_start (drain_above_start),
        .cycle_strobe (cycle_strobe), .ocp2_trip (ocp2_trip), .fb_overload (fb_overload),
        .fb_burst_low (fb_burst_low), .fb_burst_high (fb_burst_high),
        .brownout_low (brownout_low), .brownout_ok (brownout_ok),
        .thermal_hot (thermal_hot), .thermal_cool (thermal_cool), .ovp_fault (ovp_fault),
        .sw_en (sw_en), .chg_en (chg_en), .chg_reduced (chg_reduced), .ss_limit (ss_limit),
        .fb_clamp (fb_clamp), .burst_pause (burst_pause), .fault_status (fault_status)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Strobe generator: one pulse every fourth cycle while enabled.
    always @(negedge clk) begin
        cyc++;
        cycle_strobe = strobe_on && (cyc % 4 == 0);
    end

    // Behavioural reference model, advanced at each rising edge.
    always @(posedge clk) begin
        bit act, sudone, sulast, stop, hit;
        int nst, ramp, bits;
        if (!rst_n) begin
            m_st = S_OFF; m_k = 0; m_sslim = 0; m_stat = 0; m_red = 0; m_bo = 0; m_th = 0;
        end else begin
            act    = (m_st == S_SS) || (m_st == S_RUN) || (m_st == S_BURST) || (m_st == S_WARN);
            sudone = (m_k >= SU);
            sulast = (m_k == SU - 1);
            ramp   = (m_k * LMAX) / SS;
            if (ramp > LMAX) ramp = LMAX;
            stop   = brownout_low || thermal_hot || m_bo || m_th;
            hit    = cycle_strobe && ocp2_trip;
            nst    = m_st;
            if (m_st == S_OFF) begin
                if (!stop && drain_above_start) nst = S_CHG;
            end else if (m_st == S_CHG) begin
                if (stop || !drain_above_start) nst = S_OFF;
                else if (vdd_above_on) nst = S_SS;
            end else if (m_st == S_WAIT) begin
                if (vdd_below_restart) nst = S_CHG;
            end else if (stop) nst = S_OFF;
            else if (vdd_below_off) nst = drain_above_start ? S_WAIT : S_OFF;
            else if (ovp_fault || (fb_overload && sudone)) nst = S_WAIT;
            else if (m_st == S_SS) begin
                if (hit) nst = S_WARN; else if (sulast || sudone) nst = S_RUN;
            end else if (m_st == S_RUN) begin
                if (hit) nst = S_WARN; else if (fb_burst_low) nst = S_BURST;
            end else if (m_st == S_WARN) begin
                if (hit) nst = S_WAIT; else if (cycle_strobe) nst = sudone ? S_RUN : S_SS;
            end else if (m_st == S_BURST) begin
                if (fb_burst_high) nst = S_RUN;
            end
            bits = 0;
            if (m_st == S_WARN && hit)   bits |= 1;
            if (fb_overload && sudone)   bits |= 2;
            if (ovp_fault)               bits |= 4;
            if (vdd_below_off)           bits |= 8;
            if (brownout_low)            bits |= 16;
            if (thermal_hot)             bits |= 32;
            if (act) m_stat |= bits;
            if (m_st == S_CHG && nst == S_SS) begin
                m_stat = 0;
                m_red  = 0;
            end
            if (nst == S_WAIT && m_st != S_WAIT) m_red = 1;
            if (!act) m_sslim = 0;
            else if (cycle_strobe) m_sslim = ramp;
            if (!act) m_k = 0;
            else if (m_k < SU) m_k++;
            if (brownout_low) m_bo = 1; else if (brownout_ok) m_bo = 0;
            if (thermal_hot) m_th = 1; else if (thermal_cool) m_th = 0;
            m_st = nst;
        end
    end

    // Every-clock comparison against the model.
    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R2 sw_en model", sw_en, int'(m_st == S_SS || m_st == S_RUN || m_st == S_WARN));
            chk("R2 chg_en model", chg_en, int'(m_st == S_CHG));
            chk("R8 chg_reduced model", chg_reduced, int'(m_st == S_CHG && m_red));
            chk("R4 fb_clamp model", fb_clamp, int'(m_st == S_SS || (m_st == S_WARN && m_k < SU)));
            chk("R10 burst_pause model", burst_pause, int'(m_st == S_BURST));
            chk("R3 ss_limit model", ss_limit, m_sslim);
            chk("R12 fault_status model", fault_status, m_stat);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Auto-restart from fault wait through the restart level.
    task automatic restart_from_wait();
        vdd_below_restart = 1;
        step(2);
        chk("R8 reduced charge", chg_reduced, 1);
        vdd_below_restart = 0;
        vdd_above_on = 1;
        step(2);
        chk("R12 cleared on restart", fault_status, 0);
        vdd_above_on = 0;
        step(80);
    endtask

    // Normal start from charging.
    task automatic start_switching();
        vdd_above_on = 1;
        step(2);
        vdd_above_on = 0;
        step(80);
    endtask

    initial begin
        step(4);
        chk("R1 sw_en reset", sw_en, 0);
        chk("R1 chg_en reset", chg_en, 0);
        chk("R1 ss_limit reset", ss_limit, 0);
        chk("R1 status reset", fault_status, 0);
        cmp_en = 1;
        rst_n = 1;
        step(3);
        chk("R2 no charge without drain", chg_en, 0);
        drain_above_start = 1;
        step(2);
        chk("R2 charge with drain", chg_en, 1);
        chk("R8 normal current first start", chg_reduced, 0);
        strobe_on = 1;
        vdd_above_on = 1;
        step(2);
        chk("R2 switching after on", sw_en, 1);
        chk("R4 clamp in window", fb_clamp, 1);
        vdd_above_on = 0;
        fb_overload = 1;
        step(30);
        chk("R4 overload masked", sw_en, 1);
        fb_overload = 0;
        step(50);
        chk("R4 clamp released", fb_clamp, 0);
        chk("R3 ramp at max", ss_limit, LMAX);
        // Burst with hysteresis.
        fb_burst_low = 1; fb_burst_high = 0;
        step(2);
        chk("R10 burst entered", burst_pause, 1);
        fb_burst_low = 0;
        step(5);
        chk("R10 burst held in band", burst_pause, 1);
        fb_burst_high = 1;
        step(2);
        chk("R10 burst exit", sw_en, 1);
        // Single overcurrent trip.
        ocp2_trip = 1;
        step(4);
        ocp2_trip = 0;
        step(6);
        chk("R6 single trip keeps switching", sw_en, 1);
        chk("R6 single trip no cause", fault_status, 0);
        // Double overcurrent trip.
        ocp2_trip = 1;
        step(8);
        ocp2_trip = 0;
        step(2);
        chk("R6 double trip stops", sw_en, 0);
        chk("R12 ocp bit0", fault_status, 1);
        step(10);
        chk("R8 no charge above restart", chg_en, 0);
        restart_from_wait();
        // Overvoltage.
        ovp_fault = 1; step(1); ovp_fault = 0;
        step(2);
        chk("R7 ovp stops", sw_en, 0);
        chk("R12 ovp bit2", fault_status, 4);
        restart_from_wait();
        // Overload after window.
        fb_overload = 1; step(1); fb_overload = 0;
        step(2);
        chk("R5 overload stops", sw_en, 0);
        chk("R12 overload bit1", fault_status, 2);
        restart_from_wait();
        // Undervoltage, drain high.
        vdd_below_off = 1; step(1); vdd_below_off = 0;
        step(4);
        chk("R9 uvlo waits", chg_en, 0);
        chk("R12 uvlo bit3", fault_status, 8);
        restart_from_wait();
        // Undervoltage, drain low.
        drain_above_start = 0;
        vdd_below_off = 1; step(1); vdd_below_off = 0;
        step(5);
        chk("R9 inhibited restart", chg_en, 0);
        drain_above_start = 1;
        step(2);
        chk("R9 charge after drain", chg_en, 1);
        chk("R9 normal current", chg_reduced, 0);
        start_switching();
        // Brown-out.
        brownout_low = 1; brownout_ok = 0; step(1); brownout_low = 0;
        step(5);
        chk("R11 brownout stops", sw_en, 0);
        chk("R11 brownout holds", chg_en, 0);
        brownout_ok = 1;
        step(3);
        chk("R11 brownout resume", chg_en, 1);
        chk("R11 brownout normal current", chg_reduced, 0);
        chk("R12 brownout bit4", fault_status, 16);
        start_switching();
        // Thermal.
        thermal_hot = 1; thermal_cool = 0; step(1); thermal_hot = 0;
        step(5);
        chk("R11 thermal holds", chg_en, 0);
        thermal_cool = 1;
        step(3);
        chk("R11 thermal resume", chg_en, 1);
        chk("R12 thermal bit5", fault_status, 32);
        start_switching();
        // Coincident brown-out and overvoltage.
        brownout_low = 1; brownout_ok = 0; ovp_fault = 1;
        step(1);
        brownout_low = 0; ovp_fault = 0;
        brownout_ok = 1;
        step(3);
        chk("R13 inhibit wins", chg_en, 1);
        chk("R13 no reduced current", chg_reduced, 0);
        chk("R12 both causes", fault_status, 20);
        step(10);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule